// File: doc/BRIEF.md
# Banked Address Translator

This block turns the committed values of a cartridge bank controller's four registers into physical addresses for the storage arrays. CPU reads at $8000-$FFFF go to program ROM through two 16K windows. CPU accesses at $6000-$7FFF go to an 8K work-RAM window. PPU pattern fetches at $0000-$1FFF go to character memory through two 4K windows. The block also passes out the nametable mirroring selection. A chip enable for the RAM takes its value from the address, the RAM-disable bit and the silicon revision.

The block holds no state. A serial loader elsewhere commits the register values, and that loader also supplies a flag telling which character register it wrote last. A strap marks a 512K program-ROM board. On such a board, bit 4 of a character register drives program-ROM address bit 18, which selects the 256K half.

Top module: `bank_xlate`

## Requirements
- R1: With the program mode field (`ctrl[3:2]`) equal to 0 or 1, a 32K region is mapped. $8000-$BFFF uses bank `prg[3:1]*2`, and $C000-$FFFF uses that bank plus one.
- R2: With the program mode field equal to 2, $8000-$BFFF is fixed to the first bank of the selected 256K half, and $C000-$FFFF uses bank `prg[3:0]`.
- R3: With the program mode field equal to 3, $8000-$BFFF uses bank `prg[3:0]`, and $C000-$FFFF is fixed to the last bank. The last bank is the lesser of the bank count and 16, minus one, within the selected 256K half.
- R4: With `ctrl[4]`=0, character memory is switched 8K at a time. PPU $0000-$0FFF uses bank `chr0` with bit 0 cleared, and $1000-$1FFF uses that bank plus one.
- R5: With `ctrl[4]`=1, PPU $0000-$0FFF uses 4K bank `chr0` and $1000-$1FFF uses 4K bank `chr1`.
- R6: `ram_ce` is 1 only when `cpu_addr[15:13]`=3'b011. `ram_addr` is `cpu_addr[12:0]`. On revision B/C (`rev_a`=0), `prg[4]`=1 forces `ram_ce` to 0.
- R7: On revision A (`rev_a`=1), `prg[4]` has no effect, and the RAM is enabled throughout its window.
- R8: With `big_prg`=1, program bank bit 4 (ROM address bit 18) is bit 4 of `chr1` when `ctrl[4]`=1 and `chr1_last`=1, and bit 4 of `chr0` otherwise. With `big_prg`=0 it is 0.
- R9: `mirror` equals `ctrl[1:0]`: 0 selects one-screen lower, 1 one-screen upper, 2 vertical and 3 horizontal.
- R10: Every program bank number wraps modulo `PRG_ROM_BANKS`, and every character bank number wraps modulo `CHR_BANKS`, before the in-window offset is appended.
- R11: `rom_ce` equals `cpu_addr[15]`. `rom_addr` is the wrapped bank times 16K plus `cpu_addr[13:0]`, and `chr_addr` is the wrapped bank times 4K plus `ppu_addr[11:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl | input | 5 | Control value: mirroring [1:0], program mode [3:2], character mode [4] |
| chr0 | input | 5 | Character bank register 0 |
| chr1 | input | 5 | Character bank register 1 |
| prg | input | 5 | Program bank [3:0], RAM disable [4] |
| chr1_last | input | 1 | 1 when chr1 was the character register written last |
| rev_a | input | 1 | 1 selects revision A RAM-enable behaviour |
| big_prg | input | 1 | Strap for a 512K program ROM |
| cpu_addr | input | 16 | CPU address |
| ppu_addr | input | 13 | PPU pattern address |
| rom_addr | output | PRG_AW (19) | Physical program-ROM address |
| rom_ce | output | 1 | Program-ROM enable |
| ram_addr | output | 13 | Work-RAM address |
| ram_ce | output | 1 | Work-RAM chip enable |
| chr_addr | output | CHR_AW (17) | Physical character-memory address |
| mirror | output | 2 | Nametable mirroring code |

## Verification
Every output is a combinational function of the present inputs. Each result is therefore due in the same cycle as its stimulus, with zero register stages. The bench changes the inputs just after a rising edge and compares all outputs against its behavioural model at the following falling edge, so each comparison sees settled values. Directed sweeps cover each program mode, both character modes, both revisions and the 512K strap, with bank counts that are not powers of two to exercise wrapping. Random stimulus follows the sweeps.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;
  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    PM_WIDE_A  = 2'd0,
    PM_WIDE_B  = 2'd1,
    PM_FIX_LO  = 2'd2,
    PM_FIX_HI  = 2'd3
  } prg_mode_e;

  localparam int PRG_WIN_W = 14;
  localparam int CHR_WIN_W = 12;
  localparam int RAM_WIN_W = 13;
endpackage

// File: rtl/bx_prg_map.sv
module bx_prg_map
  import bank_xlate_pkg::*;
#(
  parameter int PRG_AW        = 19,
  parameter int PRG_ROM_BANKS = 32
) (
  input  logic [1:0]           mode,
  input  logic [3:0]           bank_nib,
  input  logic                 outer,
  input  logic [15:0]          cpu_addr,
  output logic [PRG_AW-1:0]    rom_addr
);
  localparam int BW   = PRG_AW - PRG_WIN_W;
  localparam int BWP  = BW + 1;
  localparam int LASTN = ((PRG_ROM_BANKS < 16) ? PRG_ROM_BANKS : 16) - 1;
  localparam logic [3:0]   LAST_NIB = 4'(LASTN);
  localparam logic [BW:0]  NB_W     = BWP'(PRG_ROM_BANKS);

  logic        hi_half;
  logic [3:0]  nib;
  logic [BW:0] raw;
  logic [BW:0] wrapped;

  assign hi_half = cpu_addr[14];

  always_comb begin
    unique case (prg_mode_e'(mode))
      PM_WIDE_A, PM_WIDE_B: nib = {bank_nib[3:1], hi_half};
      PM_FIX_LO:            nib = hi_half ? bank_nib : 4'd0;
      PM_FIX_HI:            nib = hi_half ? LAST_NIB : bank_nib;
      default:              nib = 4'd0;
    endcase
  end

  always_comb begin
    raw = '0;
    raw[3:0] = nib;
    if (BW > 4) raw[4] = outer;
  end

  assign wrapped  = raw % NB_W;
  assign rom_addr = {wrapped[BW-1:0], cpu_addr[PRG_WIN_W-1:0]};

  always_comb begin
    if (!$isunknown({mode, hi_half, raw})) begin
      p_wide_pair_r1: assert (!(mode[1] == 1'b0) || raw[0] == hi_half)
        else $error("32K mode bank low bit does not follow the half");
    end
    if (!$isunknown(rom_addr)) begin
      p_prg_range_r10: assert (int'(rom_addr[PRG_AW-1:PRG_WIN_W]) < PRG_ROM_BANKS)
        else $error("program bank out of range");
    end
  end
endmodule

// File: rtl/bx_chr_map.sv
module bx_chr_map
  import bank_xlate_pkg::*;
#(
  parameter int CHR_AW    = 17,
  parameter int CHR_BANKS = 32
) (
  input  logic              four_k,
  input  logic [4:0]        bank_a,
  input  logic [4:0]        bank_b,
  input  logic [12:0]       ppu_addr,
  output logic [CHR_AW-1:0] chr_addr
);
  localparam int BW  = CHR_AW - CHR_WIN_W;
  localparam int BWP = BW + 1;
  localparam logic [BW:0] NB_W = BWP'(CHR_BANKS);

  logic        upper;
  logic [4:0]  sel;
  logic [BW:0] raw;
  logic [BW:0] wrapped;

  assign upper = ppu_addr[12];

  always_comb begin
    if (four_k) sel = upper ? bank_b : bank_a;
    else        sel = {bank_a[4:1], upper};
  end

  always_comb begin
    raw = '0;
    for (int i = 0; i < 5; i++) begin
      if (i < BWP) raw[i] = sel[i];
    end
  end

  assign wrapped  = raw % NB_W;
  assign chr_addr = {wrapped[BW-1:0], ppu_addr[CHR_WIN_W-1:0]};

  always_comb begin
    if (!$isunknown({four_k, upper, raw})) begin
      p_chr_pair_r4: assert (four_k || raw[0] == upper)
        else $error("8K character mode low bit does not follow the half");
    end
    if (!$isunknown(chr_addr)) begin
      p_chr_range_r10: assert (int'(chr_addr[CHR_AW-1:CHR_WIN_W]) < CHR_BANKS)
        else $error("character bank out of range");
    end
  end
endmodule

// File: rtl/bx_ram_gate.sv
module bx_ram_gate
  import bank_xlate_pkg::*;
(
  input  logic                 rev_a,
  input  logic                 ram_off,
  input  logic [15:0]          cpu_addr,
  output logic [RAM_WIN_W-1:0] ram_addr,
  output logic                 ram_ce
);
  logic in_window;
  logic allowed;

  assign in_window = (cpu_addr[15:13] == 3'b011);
  assign allowed   = rev_a | ~ram_off;
  assign ram_ce    = in_window & allowed;
  assign ram_addr  = cpu_addr[RAM_WIN_W-1:0];

  always_comb begin
    if (!$isunknown({ram_ce, cpu_addr, rev_a, ram_off})) begin
      p_ram_window_r6: assert (!ram_ce || (cpu_addr >= 16'h6000 && cpu_addr <= 16'h7FFF))
        else $error("RAM enabled outside its window");
      p_rev_a_on_r7: assert (!(rev_a && cpu_addr[15:13] == 3'b011) || ram_ce)
        else $error("revision A RAM not enabled in window");
    end
  end
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bank_xlate_pkg::*;
#(
  parameter int PRG_AW        = 19,
  parameter int PRG_ROM_BANKS = 32,
  parameter int CHR_AW        = 17,
  parameter int CHR_BANKS     = 32
) (
  input  logic [4:0]           ctrl,
  input  logic [4:0]           chr0,
  input  logic [4:0]           chr1,
  input  logic [4:0]           prg,
  input  logic                 chr1_last,
  input  logic                 rev_a,
  input  logic                 big_prg,
  input  logic [15:0]          cpu_addr,
  input  logic [12:0]          ppu_addr,
  output logic [PRG_AW-1:0]    rom_addr,
  output logic                 rom_ce,
  output logic [12:0]          ram_addr,
  output logic                 ram_ce,
  output logic [CHR_AW-1:0]    chr_addr,
  output logic [1:0]           mirror
);
  logic    four_k;
  logic    outer;
  logic    rom_ce_w;
  mirror_e mir;

  assign four_k = ctrl[4];

  always_comb begin
    if (!big_prg)                outer = 1'b0;
    else if (four_k && chr1_last) outer = chr1[4];
    else                         outer = chr0[4];
  end

  bx_prg_map #(.PRG_AW(PRG_AW), .PRG_ROM_BANKS(PRG_ROM_BANKS)) u_prg (
    .mode     (ctrl[3:2]),
    .bank_nib (prg[3:0]),
    .outer    (outer),
    .cpu_addr (cpu_addr),
    .rom_addr (rom_addr)
  );

  bx_chr_map #(.CHR_AW(CHR_AW), .CHR_BANKS(CHR_BANKS)) u_chr (
    .four_k   (four_k),
    .bank_a   (chr0),
    .bank_b   (chr1),
    .ppu_addr (ppu_addr),
    .chr_addr (chr_addr)
  );

  bx_ram_gate u_ram (
    .rev_a    (rev_a),
    .ram_off  (prg[4]),
    .cpu_addr (cpu_addr),
    .ram_addr (ram_addr),
    .ram_ce   (ram_ce)
  );

  assign rom_ce_w = cpu_addr[15];
  assign rom_ce   = rom_ce_w;
  assign mir      = mirror_e'(ctrl[1:0]);
  assign mirror   = mir;

  always_comb begin
    if (!$isunknown({rom_ce, ram_ce})) begin
      p_rom_ram_excl_r11: assert (!(rom_ce && ram_ce))
        else $error("ROM and RAM enabled together");
    end
  end
endmodule

// File: tb/sim_bank_xlate.sv
`timescale 1ns/1ps
module sim_bank_xlate;
  localparam int PRG_AW = 19;
  localparam int PB     = 24;
  localparam int CHR_AW = 17;
  localparam int CB     = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  ctrl, chr0, chr1, prg;
  logic        chr1_last, rev_a, big_prg;
  logic [15:0] cpu_addr;
  logic [12:0] ppu_addr;
  logic [PRG_AW-1:0] rom_addr;
  logic        rom_ce, ram_ce;
  logic [12:0] ram_addr;
  logic [CHR_AW-1:0] chr_addr;
  logic [1:0]  mirror;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  bank_xlate #(.PRG_AW(PRG_AW), .PRG_ROM_BANKS(PB), .CHR_AW(CHR_AW), .CHR_BANKS(CB)) u0 (
    .ctrl(ctrl), .chr0(chr0), .chr1(chr1), .prg(prg), .chr1_last(chr1_last),
    .rev_a(rev_a), .big_prg(big_prg), .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
    .rom_addr(rom_addr), .rom_ce(rom_ce), .ram_addr(ram_addr), .ram_ce(ram_ce),
    .chr_addr(chr_addr), .mirror(mirror)
  );

  function automatic int model_prg_bank();
    int o, p, hi, v, lastn;
    o  = 0;
    if (big_prg != 0) begin
      if (ctrl[4] && chr1_last) o = chr1[4] ? 16 : 0;
      else                      o = chr0[4] ? 16 : 0;
    end
    p  = int'(prg[3:0]);
    hi = int'(cpu_addr[14]);
    lastn = ((PB < 16) ? PB : 16) - 1;
    case (int'(ctrl[3:2]))
      0, 1:    v = (p / 2) * 2 + hi;
      2:       v = hi ? p : 0;
      default: v = hi ? lastn : p;
    endcase
    return (v + o) % PB;
  endfunction

  function automatic int model_chr_bank();
    int v;
    if (ctrl[4]) v = ppu_addr[12] ? int'(chr1) : int'(chr0);
    else         v = (int'(chr0) / 2) * 2 + int'(ppu_addr[12]);
    return v % CB;
  endfunction

  function automatic string prg_tag();
    if (big_prg) return "R8/R10";
    case (int'(ctrl[3:2]))
      0, 1:    return "R1";
      2:       return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic compare_all();
    longint exp_rom, exp_chr;
    bit exp_ram_ce;
    exp_rom = longint'(model_prg_bank()) * 16384 + longint'(cpu_addr[13:0]);
    exp_chr = longint'(model_chr_bank()) * 4096 + longint'(ppu_addr[11:0]);
    exp_ram_ce = (cpu_addr >= 16'h6000 && cpu_addr <= 16'h7FFF) && (rev_a || !prg[4]);

    checks++;
    if (longint'(rom_addr) != exp_rom) begin
      fails++;
      $display("FAIL %s rom_addr actual %h expected %h", prg_tag(), rom_addr, exp_rom);
    end
    checks++;
    if (longint'(chr_addr) != exp_chr) begin
      fails++;
      $display("FAIL %s chr_addr actual %h expected %h", ctrl[4] ? "R5" : "R4", chr_addr, exp_chr);
    end
    checks++;
    if (ram_ce != exp_ram_ce || ram_addr != cpu_addr[12:0]) begin
      fails++;
      $display("FAIL %s ram_ce/addr actual %b/%h expected %b/%h", rev_a ? "R7" : "R6",
               ram_ce, ram_addr, exp_ram_ce, cpu_addr[12:0]);
    end
    checks++;
    if (rom_ce != cpu_addr[15]) begin
      fails++;
      $display("FAIL R11 rom_ce actual %b expected %b", rom_ce, cpu_addr[15]);
    end
    checks++;
    if (mirror != ctrl[1:0]) begin
      fails++;
      $display("FAIL R9 mirror actual %0d expected %0d", mirror, ctrl[1:0]);
    end
  endtask

  // compare every clock at the falling edge, after inputs settle
  always @(negedge clk) begin
    if (!$isunknown({ctrl, chr0, chr1, prg, chr1_last, rev_a, big_prg, cpu_addr, ppu_addr}))
      compare_all();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic drive(input logic [4:0] c, input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] p, input logic l, input logic r, input logic g,
                       input logic [15:0] ca, input logic [12:0] pa);
    @(posedge clk);
    #0.5;
    ctrl = c; chr0 = a; chr1 = b; prg = p; chr1_last = l; rev_a = r; big_prg = g;
    cpu_addr = ca; ppu_addr = pa;
  endtask

  initial begin
    // all-zero inputs act as the reset state
    drive(5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 16'h8000, 13'h0000);
    // R1 32K modes, both halves, odd bank number
    for (int m = 0; m < 2; m++) begin
      drive(5'(m << 2), 5'd0, 5'd0, 5'd7, 0, 0, 0, 16'h8123, 13'h0);
      drive(5'(m << 2), 5'd0, 5'd0, 5'd7, 0, 0, 0, 16'hC456, 13'h0);
    end
    // R2 fixed low, switched high
    drive(5'b01000, 0, 0, 5'd9, 0, 0, 0, 16'h9ABC, 13'h0);
    drive(5'b01000, 0, 0, 5'd9, 0, 0, 0, 16'hEABC, 13'h0);
    // R3 switched low, fixed last
    drive(5'b01100, 0, 0, 5'd5, 0, 0, 0, 16'hA000, 13'h0);
    drive(5'b01100, 0, 0, 5'd5, 0, 0, 0, 16'hFFFF, 13'h0);
    // R4 8K character mode with odd chr0, both halves; R10 wrap (chr 13 % 12)
    drive(5'b00000, 5'd13, 5'd3, 0, 0, 0, 0, 16'h0, 13'h0ABC);
    drive(5'b00000, 5'd13, 5'd3, 0, 0, 0, 0, 16'h0, 13'h1ABC);
    // R5 4K character mode
    drive(5'b10000, 5'd5, 5'd9, 0, 1, 0, 0, 16'h0, 13'h0111);
    drive(5'b10000, 5'd5, 5'd9, 0, 1, 0, 0, 16'h0, 13'h1222);
    // R6 RAM window edges and disable bit
    drive(5'd0, 0, 0, 5'h00, 0, 0, 0, 16'h6000, 13'h0);
    drive(5'd0, 0, 0, 5'h00, 0, 0, 0, 16'h7FFF, 13'h0);
    drive(5'd0, 0, 0, 5'h00, 0, 0, 0, 16'h5FFF, 13'h0);
    drive(5'd0, 0, 0, 5'h10, 0, 0, 0, 16'h6800, 13'h0);
    // R7 revision A ignores the disable bit
    drive(5'd0, 0, 0, 5'h10, 0, 1, 0, 16'h6800, 13'h0);
    // R8 512K: outer bit from chr0 in 8K mode, from last-written in 4K mode
    drive(5'b01100, 5'h10, 5'h00, 5'd2, 1, 0, 1, 16'h8000, 13'h0);
    drive(5'b11100, 5'h10, 5'h00, 5'd2, 1, 0, 1, 16'h8000, 13'h0);
    drive(5'b11100, 5'h00, 5'h10, 5'd2, 1, 0, 1, 16'hC000, 13'h0);
    drive(5'b11100, 5'h00, 5'h10, 5'd2, 0, 0, 1, 16'hC000, 13'h0);
    drive(5'b01000, 5'h10, 5'h00, 5'd15, 0, 0, 1, 16'hC000, 13'h0);
    drive(5'b01100, 5'h10, 5'h00, 5'd15, 0, 0, 0, 16'hC000, 13'h0);
    // R9 every mirroring code
    for (int k = 0; k < 4; k++) drive(5'(k), 0, 0, 0, 0, 0, 0, 16'h0, 13'h0);
    // random stimulus across all fields
    for (int i = 0; i < 3000; i++) begin
      drive(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 16'($urandom), 13'($urandom));
    end
    @(posedge clk);
    @(negedge clk);
    done = 1;
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule